// File: doc/BRIEF.md
# Mixed-Radix Bus Cycle Timer

This block keeps bus time as a free-running counter made of three fields. A sub-cycle offset advances once for each pulse of a 24.576 MHz tick enable. A cycle count advances each time the offset wraps. A seconds count advances each time the cycle count wraps. The offset wraps at 3072 and the cycle count wraps at 8000, so the counter is a cascade of mixed-radix digits, not a single binary counter. All three fields are packed into one 32-bit word, and the word is available in parallel on every cycle.

The block also drives the same time as one linear tick total, the weighted sum of the three fields. A load strobe can overwrite the whole word in a single cycle. A field in the loaded value that lies outside its legal range is written as zero.

Top module: `cyc_timer`

## Requirements
- R1: A synchronous reset sets `time_word` and `tick_total` to zero.
- R2: The offset field, bits 11:0 of `time_word`, goes up by one on each clock edge where `tick_en` is high. No field changes on an edge where `tick_en` and `load_en` are both low.
- R3: When the offset is 3071 and a tick arrives, the offset returns to 0 and the cycle count goes up by one on that same edge.
- R4: The cycle count, bits 24:12, counts from 0 to 7999. When it wraps to 0, the seconds field, bits 31:25, goes up by one on that same edge.
- R5: The seconds field wraps from 127 to 0 with no other indication. A tick at word value {127, 7999, 3071} gives an all-zero word.
- R6: When `load_en` is high, all three fields take the value of `load_word` on the next edge. This holds even if `tick_en` is also high in that cycle.
- R7: On a load, an offset of 3072 or more is stored as 0, and a cycle count of 8000 or more is stored as 0. Each field is clamped on its own, and the other fields are stored as given.
- R8: `tick_total` always equals offset + 3072 × cycle count + 24,576,000 × seconds for the current `time_word`, with no added latency.
- R9: The offset never holds a value above 3071, and the cycle count never holds a value above 7999.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Advances the timer by one tick |
| load_en | input | 1 | Writes load_word into the timer; takes priority over tick_en |
| load_word | input | 32 | Packed value to load: {seconds, cycle count, offset} |
| time_word | output | 32 | Packed current time: {seconds[31:25], count[24:12], offset[11:0]} |
| tick_total | output | 32 | Linear tick total computed from the fields |

## Verification
The bench builds the block with its default parameters: a 12-bit offset that wraps at 3072, a 13-bit count that wraps at 8000, and a 7-bit seconds field. With these values, the total tick range fits exactly in 32 bits.

Loading a value one tick below each wrap point reaches every carry chain in a few cycles. This covers the single, double and triple wraps, including the rollover of the seconds field to zero, without ticking through 24 million states. One directed run ticks across two full offset cycles from zero. This checks that the cascade carries correctly through repeated wraps and not only from a loaded value.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;

   // Bits needed to hold every tick count the cascade can represent.
   function automatic int lin_width(input int off_mod, input int cnt_mod, input int sec_w);
      longint unsigned span;
      span = longint'(off_mod) * longint'(cnt_mod) * (64'd1 << sec_w);
      return $clog2(span);
   endfunction

endpackage

// File: rtl/cyc_digit.sv
module cyc_digit #(
   parameter int W   = 12,
   parameter int MOD = 3072
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         carry_in,
   output logic [W-1:0] value,
   output logic         carry_out
);

   generate
      if (MOD < 2 || MOD > (1 << W)) begin : g_bad_mod
         $error("cyc_digit: MOD must lie in 2 .. 2**W");
      end
   endgenerate

   logic         at_top;
   logic [W-1:0] inc_val;
   logic [W-1:0] load_fit;

   assign at_top    = (value == W'(MOD - 1));
   assign carry_out = carry_in & at_top;

   generate
      if (MOD == (1 << W)) begin : g_pow2
         // Natural binary wrap, every load value is legal.
         assign inc_val  = value + W'(1);
         assign load_fit = load_val;
      end else begin : g_modn
         assign inc_val  = at_top ? '0 : value + W'(1);
         assign load_fit = (load_val >= W'(MOD)) ? '0 : load_val;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)           value <= '0;
      else if (load)     value <= load_fit;
      else if (carry_in) value <= inc_val;
   end

   AST_DIGIT_BOUND: assert property (@(posedge clk) disable iff (rst)
      ({1'b0, value} < (W+1)'(MOD))); // R9

   AST_DIGIT_WRAP: assert property (@(posedge clk) disable iff (rst)
      (!load && carry_in && at_top) |=> (value == '0)); // R3 R4 R5

   AST_DIGIT_STEP: assert property (@(posedge clk) disable iff (rst)
      (!load && carry_in && !at_top) |=> (value == $past(value) + W'(1))); // R2

   AST_DIGIT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!load && !carry_in) |=> $stable(value)); // R2

   AST_DIGIT_LOAD: assert property (@(posedge clk) disable iff (rst)
      (load && ({1'b0, load_val} < (W+1)'(MOD))) |=> (value == $past(load_val))); // R6

   AST_DIGIT_CLAMP: assert property (@(posedge clk) disable iff (rst)
      (load && ({1'b0, load_val} >= (W+1)'(MOD))) |=> (value == '0)); // R7

endmodule

// File: rtl/cyc_linear.sv
module cyc_linear #(
   parameter int OFF_W   = 12,
   parameter int CNT_W   = 13,
   parameter int SEC_W   = 7,
   parameter int OFF_MOD = 3072,
   parameter int CNT_MOD = 8000,
   parameter int LIN_W   = 32
) (
   input  logic [OFF_W-1:0] off,
   input  logic [CNT_W-1:0] cnt,
   input  logic [SEC_W-1:0] sec,
   output logic [LIN_W-1:0] total
);

   localparam logic [LIN_W-1:0] CYC_WEIGHT = LIN_W'(OFF_MOD);
   localparam logic [LIN_W-1:0] SEC_WEIGHT = LIN_W'(longint'(OFF_MOD) * longint'(CNT_MOD));

   always_comb begin
      total = LIN_W'(off)
            + LIN_W'(cnt) * CYC_WEIGHT
            + LIN_W'(sec) * SEC_WEIGHT;
   end

endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
   import cyc_timer_pkg::*;
#(
   parameter  int OFF_W   = 12,
   parameter  int CNT_W   = 13,
   parameter  int SEC_W   = 7,
   parameter  int OFF_MOD = 3072,
   parameter  int CNT_MOD = 8000,
   localparam int WORD_W  = OFF_W + CNT_W + SEC_W,
   localparam int LIN_W   = lin_width(OFF_MOD, CNT_MOD, SEC_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick_en,
   input  logic              load_en,
   input  logic [WORD_W-1:0] load_word,
   output logic [WORD_W-1:0] time_word,
   output logic [LIN_W-1:0]  tick_total
);

   localparam int CNT_LSB = OFF_W;
   localparam int SEC_LSB = OFF_W + CNT_W;
   localparam int NDIG    = 3;

   localparam int DIG_W   [NDIG] = '{OFF_W, CNT_W, SEC_W};
   localparam int DIG_MOD [NDIG] = '{OFF_MOD, CNT_MOD, 1 << SEC_W};
   localparam int DIG_LSB [NDIG] = '{0, CNT_LSB, SEC_LSB};

   generate
      if (LIN_W > 64) begin : g_bad_width
         $error("cyc_timer: tick range exceeds 64 bits");
      end
   endgenerate

   logic [NDIG:0] carry;
   assign carry[0] = tick_en;

   // One stage per field; each carry is combinational so a wrap ripples
   // through every higher field on the same edge.
   for (genvar d = 0; d < NDIG; d++) begin : g_dig
      logic [DIG_W[d]-1:0] val;
      cyc_digit #(.W(DIG_W[d]), .MOD(DIG_MOD[d])) u_digit (
         .clk      (clk),
         .rst      (rst),
         .load     (load_en),
         .load_val (load_word[DIG_LSB[d] +: DIG_W[d]]),
         .carry_in (carry[d]),
         .value    (val),
         .carry_out(carry[d+1])
      );
      assign time_word[DIG_LSB[d] +: DIG_W[d]] = val;
   end

   cyc_linear #(
      .OFF_W(OFF_W), .CNT_W(CNT_W), .SEC_W(SEC_W),
      .OFF_MOD(OFF_MOD), .CNT_MOD(CNT_MOD), .LIN_W(LIN_W)
   ) u_linear (
      .off  (time_word[OFF_W-1:0]),
      .cnt  (time_word[SEC_LSB-1:CNT_LSB]),
      .sec  (time_word[WORD_W-1:SEC_LSB]),
      .total(tick_total)
   );

   localparam logic [LIN_W-1:0] LIN_MAX =
      LIN_W'(longint'(OFF_MOD) * longint'(CNT_MOD) * (longint'(1) << SEC_W) - 1);

   AST_LIN_STEP: assert property (@(posedge clk) disable iff (rst)
      (!load_en && tick_en && tick_total != LIN_MAX)
      |=> (tick_total == $past(tick_total) + LIN_W'(1))); // R8

   AST_LIN_ROLL: assert property (@(posedge clk) disable iff (rst)
      (!load_en && tick_en && tick_total == LIN_MAX) |=> (time_word == '0)); // R5

   AST_SAME_EDGE: assert property (@(posedge clk) disable iff (rst)
      (!load_en && carry[1])
      |=> (time_word[SEC_LSB-1:CNT_LSB] != $past(time_word[SEC_LSB-1:CNT_LSB]))); // R3

endmodule

// File: tb/cyc_timer_test.sv
module cyc_timer_test;

   logic        clk = 1'b0;
   logic        rst;
   logic        tick_en;
   logic        load_en;
   logic [31:0] load_word;
   logic [31:0] time_word;
   logic [31:0] tick_total;

   int checks   = 0;
   int failures = 0;
   bit done     = 0;

   always #4 clk = ~clk;   // 125 MHz

   cyc_timer uut (
      .clk(clk), .rst(rst), .tick_en(tick_en), .load_en(load_en),
      .load_word(load_word), .time_word(time_word), .tick_total(tick_total)
   );

   function automatic logic [31:0] mk(input int s, input int c, input int o);
      return {7'(s), 13'(c), 12'(o)};
   endfunction

   function automatic longint unsigned lin(input logic [31:0] w);
      return longint'(w[11:0]) + 64'd3072 * w[24:12] + 64'd24576000 * w[31:25];
   endfunction

   task automatic chk(input string req, input logic [31:0] exp);
      checks++;
      if (time_word !== exp || longint'(tick_total) != lin(exp)) begin
         failures++;
         $display("FAIL %s: word=%h total=%0d expected word=%h total=%0d",
                  req, time_word, tick_total, exp, lin(exp));
      end
   endtask

   task automatic do_load(input logic [31:0] v, input logic tk);
      load_word = v; load_en = 1'b1; tick_en = tk;
      @(negedge clk);
      load_en = 1'b0; tick_en = 1'b0;
   endtask

   task automatic do_ticks(input int n);
      for (int k = 0; k < n; k++) begin
         tick_en = 1'b1;
         @(negedge clk);
      end
      tick_en = 1'b0;
   endtask

   // Vectors: load value, ticks after it, expected word, requirement.
   localparam int NV = 8;
   localparam logic [31:0] V_LOAD [NV] = '{
      {7'd0,   13'd0,    12'd5},
      {7'd0,   13'd0,    12'd3071},
      {7'd0,   13'd7999, 12'd3070},
      {7'd127, 13'd7999, 12'd3071},
      {7'd3,   13'd100,  12'd4095},
      {7'd5,   13'd8191, 12'd17},
      {7'd2,   13'd8000, 12'd3072},
      {7'd9,   13'd42,   12'd3071}};
   localparam int V_TICKS [NV] = '{3, 1, 2, 1, 0, 0, 1, 2};
   localparam logic [31:0] V_EXP [NV] = '{
      {7'd0,   13'd0,   12'd8},
      {7'd0,   13'd1,   12'd0},
      {7'd1,   13'd0,   12'd0},
      {7'd0,   13'd0,   12'd0},
      {7'd3,   13'd100, 12'd0},
      {7'd5,   13'd0,   12'd17},
      {7'd2,   13'd0,   12'd1},
      {7'd9,   13'd43,  12'd1}};
   localparam string V_REQ [NV] = '{"R2", "R3", "R4", "R5", "R7", "R7", "R7", "R3"};

   initial begin
      rst = 1'b1; tick_en = 1'b0; load_en = 1'b0; load_word = '0;
      repeat (3) @(negedge clk);
      chk("R1 reset", 32'h0);
      rst = 1'b0;
      @(negedge clk);
      chk("R2 idle hold", 32'h0);

      for (int i = 0; i < NV; i++) begin
         do_load(V_LOAD[i], 1'b0);
         do_ticks(V_TICKS[i]);
         chk(V_REQ[i], V_EXP[i]);
      end

      // R8: linear total right after a load with large fields
      do_load(mk(100, 7000, 2000), 1'b0);
      chk("R8 linear", mk(100, 7000, 2000));

      // R2: no change without tick or load
      repeat (5) @(negedge clk);
      chk("R2 hold", mk(100, 7000, 2000));

      // R6: load wins over a simultaneous tick
      do_load(mk(1, 2, 3), 1'b1);
      chk("R6 priority", mk(1, 2, 3));

      // R3/R9: run across two full offset cycles from zero
      do_load(32'h0, 1'b0);
      do_ticks(2 * 3072 + 5);
      chk("R3 long run", mk(0, 2, 5));

      // R1: reset in mid-run clears everything
      tick_en = 1'b1; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0; tick_en = 1'b0;
      chk("R1 mid reset", 32'h0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule